// File: doc/BRIEF.md
# Four-Channel Sequential SAR Conversion Controller

This block is the digital control core of a four-channel, 12-bit converter whose four sample-and-hold stages freeze together. A rising edge on the asynchronous conversion-start input is brought into the clock domain. The block then raises a hold output that freezes every channel at once. It runs a successive-approximation search on each channel in a fixed order, presenting an offset-binary trial code and a channel index to an external comparator, and reading back one decision bit per clock.

Each finished result goes into its own result register, stored as two's complement. After the last channel is stored, an active-low interrupt falls. A host reads the results over a 12-bit three-state bus using active-low select and read strobes. It does not pass an address. An internal pointer selects the register, steps forward after each read, and rewinds to the first channel whenever a conversion is accepted. Misuse is tolerated and recorded in two sticky flags: a start edge while busy, and a read while busy.

Top module: `quad_sar_ctrl`

## Requirements
- R1: After reset, and with `conv_start` rising between clock edges, `hold` is low through the second rising clock edge and high after the third (two synchronizer stages plus one edge-detect stage).
- R2: Each channel is resolved by 12 trials, MSB first. The first trial code on `sar_trial` is 0x800. A trial bit is kept when `cmp_in` is 1, meaning the sampled level is at or above the trial code. The stored result is the final offset-binary code with bit 11 inverted, which is two's complement.
- R3: `sar_chan` takes the values 0, 1, 2, 3 (channels 1 to 4) strictly in that order, one step at a time. Each result is written before the next channel's trials begin.
- R4: `irq_n` falls, and `hold` drops, on the 78th rising clock edge after `conv_start` rises.
- R5: `irq_n` goes low only when the channel 4 result is written. It returns high one clock after the falling edge of the first read strobe (`cs_n` and `rd_n` both low) once the conversion has finished.
- R6: An accepted conversion start rewinds the read pointer to channel 1. Successive completed reads return channels 1, 2, 3, 4. No register can be addressed directly.
- R7: A fifth read after four completed reads returns channel 1 again (the pointer wraps).
- R8: `db` is driven only while both `cs_n` and `rd_n` are low, with the register at the pointer, and is high-impedance otherwise.
- R9: A start edge while a conversion is running is ignored: timing and results are unchanged. `start_overrun` goes high and stays high until reset.
- R10: A read while `hold` is high returns the previous content of the register at the pointer and does not advance the pointer. `busy_read` goes high and stays high until reset.
- R11: Reset (synchronous, active high) leaves `irq_n` high, `hold` low, both flags low, every result register at zero and the pointer at channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Asynchronous conversion start; its rising edge starts a conversion |
| cmp_in | input | 1 | Comparator decision: 1 when the sampled level is at or above `sar_trial` |
| hold | output | 1 | High while all four sample-and-holds are frozen |
| sar_chan | output | 2 | Channel being resolved (0 to 3) |
| sar_trial | output | 12 | Offset-binary trial code for the comparator, 0 outside trials |
| irq_n | output | 1 | Active-low completion interrupt |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| db | output | 12 | Three-state result bus, two's complement |
| start_overrun | output | 1 | Sticky: a start edge arrived while busy |
| busy_read | output | 1 | Sticky: a read arrived while busy |

## Verification
The bench drives `conv_start` half a clock away from an edge and counts rising edges from there. `hold` must still be low after the second edge and high after the third, and `irq_n` is expected low exactly after edge 78. Both are sampled on the falling edge that follows the counted rising edge. Bus data is combinational from the strobes, so it is checked one nanosecond after the strobes fall. The pointer step and the interrupt release each come one edge later, so they are checked on the next falling edge. Comparator decisions are formed from ideal channel values, so the expected result of every channel is simply the signed value the bench chose.

// File: rtl/quad_sar_pkg.sv
package quad_sar_pkg;

    localparam int DEF_DATA_W    = 12;
    localparam int DEF_CHANNELS  = 4;
    localparam int DEF_SETUP_CYC = 3;
    localparam int DEF_GAP_CYC   = 6;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_TRIAL = 2'd2,
        PH_GAP   = 2'd3
    } sar_phase_t;

endpackage

// File: rtl/quad_sar_start_sync.sv
module quad_sar_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], async_in};
            last_q <= chain[STAGES-1];
        end
    end

    assign rise_pulse = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/quad_sar_sequencer.sv
module quad_sar_sequencer
    import quad_sar_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int CHANNELS  = DEF_CHANNELS,
    parameter int SETUP_CYC = DEF_SETUP_CYC,
    parameter int GAP_CYC   = DEF_GAP_CYC
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic                        cmp_in,
    output logic                        accept,
    output logic                        hold,
    output logic [$clog2(CHANNELS)-1:0] chan,
    output logic [DATA_W-1:0]           trial,
    output logic                        wr_en,
    output logic [DATA_W-1:0]           wr_data,
    output logic                        overrun
);
    localparam int CW     = $clog2(CHANNELS);
    localparam int BW     = $clog2(DATA_W);
    localparam int MAXCYC = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
    localparam int TW     = $clog2(MAXCYC + 1);
    localparam logic [CW-1:0]     LAST_CH  = CW'(CHANNELS - 1);
    localparam logic [BW-1:0]     TOP_BIT  = BW'(DATA_W - 1);
    localparam logic [TW-1:0]     SETUP_END = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0]     GAP_END   = TW'(GAP_CYC - 1);
    localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

    sar_phase_t          phase;
    logic [TW-1:0]       tick;
    logic [BW-1:0]       bit_idx;
    logic [DATA_W-1:0]   acc;
    logic                done;

    assign accept  = start && (phase == PH_IDLE);
    assign hold    = (phase != PH_IDLE);
    assign trial   = (phase == PH_TRIAL) ? (acc | (DATA_W'(1) << bit_idx)) : '0;
    assign wr_en   = (phase == PH_GAP) && (tick == GAP_END);
    assign wr_data = acc ^ SIGN_FLIP;
    assign done    = wr_en && (chan == LAST_CH);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            tick    <= '0;
            bit_idx <= '0;
            acc     <= '0;
            chan    <= '0;
            overrun <= 1'b0;
        end else begin
            if (start && phase != PH_IDLE)
                overrun <= 1'b1;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SETUP;
                        tick  <= '0;
                        chan  <= '0;
                        acc   <= '0;
                    end
                end
                PH_SETUP: begin
                    if (tick == SETUP_END) begin
                        phase   <= PH_TRIAL;
                        bit_idx <= TOP_BIT;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                PH_TRIAL: begin
                    if (cmp_in)
                        acc <= trial;
                    if (bit_idx == '0) begin
                        phase <= PH_GAP;
                        tick  <= '0;
                    end else begin
                        bit_idx <= bit_idx - 1'b1;
                    end
                end
                PH_GAP: begin
                    if (tick == GAP_END) begin
                        if (chan == LAST_CH) begin
                            phase <= PH_IDLE;
                        end else begin
                            chan    <= chan + 1'b1;
                            acc     <= '0;
                            bit_idx <= TOP_BIT;
                            phase   <= PH_TRIAL;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R1: an accepted start freezes the holds on the next edge
    assert_start_freezes_R1: assert property (@(posedge clk) disable iff (rst)
        accept |=> hold);

    // R3: channels advance by exactly one after each stored result
    assert_channel_order_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && chan != LAST_CH) |=> (chan == CW'($past(chan) + 1'b1)));

    // R9: a start while busy neither ends the run early nor goes unrecorded
    assert_overrun_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (start && hold && !done) |=> (hold && overrun));

    // R2: the first trial of every channel tests the MSB alone
    assert_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(phase == PH_TRIAL)) |-> (trial == SIGN_FLIP));
endmodule

// File: rtl/quad_sar_result_bank.sv
module quad_sar_result_bank
    import quad_sar_pkg::*;
#(
    parameter int DATA_W   = DEF_DATA_W,
    parameter int CHANNELS = DEF_CHANNELS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rewind,
    input  logic                        busy,
    input  logic                        wr_en,
    input  logic [$clog2(CHANNELS)-1:0] wr_idx,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        rd_act,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        irq_n,
    output logic                        busy_read
);
    localparam int CW = $clog2(CHANNELS);
    localparam logic [CW-1:0] LAST_CH = CW'(CHANNELS - 1);

    logic [DATA_W-1:0] regs [CHANNELS];
    logic [CW-1:0]     ptr;
    logic              rd_prev;
    logic              rd_fall;
    logic              rd_end;

    assign rd_fall = rd_act && !rd_prev;
    assign rd_end  = !rd_act && rd_prev;
    assign rd_data = regs[ptr];

    generate
        for (genvar g = 0; g < CHANNELS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= '0;
                else if (wr_en && wr_idx == CW'(g))
                    regs[g] <= wr_data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= '0;
            rd_prev   <= 1'b0;
            irq_n     <= 1'b1;
            busy_read <= 1'b0;
        end else begin
            rd_prev <= rd_act;
            if (rewind)
                ptr <= '0;
            else if (rd_end && !busy)
                ptr <= (ptr == LAST_CH) ? '0 : ptr + 1'b1;
            if (wr_en && wr_idx == LAST_CH)
                irq_n <= 1'b0;
            else if (rd_fall && !busy)
                irq_n <= 1'b1;
            if (rd_fall && busy)
                busy_read <= 1'b1;
        end
    end

    // R5: completion is flagged only by the last channel's write
    assert_irq_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> ($past(wr_en) && $past(wr_idx) == LAST_CH));

    // R6: an accepted start points the next read at channel 1
    assert_rewind_R6: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (ptr == '0));

    // R10: a read while busy leaves the pointer where it was
    assert_busy_read_keeps_ptr_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !rewind) |=> $stable(ptr));
endmodule

// File: rtl/quad_sar_ctrl.sv
module quad_sar_ctrl
    import quad_sar_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int CHANNELS  = DEF_CHANNELS,
    parameter int SETUP_CYC = DEF_SETUP_CYC,
    parameter int GAP_CYC   = DEF_GAP_CYC,
    parameter int SYNC_STG  = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        conv_start,
    input  logic                        cmp_in,
    output logic                        hold,
    output logic [$clog2(CHANNELS)-1:0] sar_chan,
    output logic [DATA_W-1:0]           sar_trial,
    output logic                        irq_n,
    input  logic                        cs_n,
    input  logic                        rd_n,
    output logic [DATA_W-1:0]           db,
    output logic                        start_overrun,
    output logic                        busy_read
);
    localparam int CW = $clog2(CHANNELS);

    logic              start_pulse;
    logic              accept;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic              rd_act;

    assign rd_act = !cs_n && !rd_n;

    quad_sar_start_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .async_in   (conv_start),
        .rise_pulse (start_pulse)
    );

    quad_sar_sequencer #(
        .DATA_W    (DATA_W),
        .CHANNELS  (CHANNELS),
        .SETUP_CYC (SETUP_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start_pulse),
        .cmp_in  (cmp_in),
        .accept  (accept),
        .hold    (hold),
        .chan    (sar_chan),
        .trial   (sar_trial),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .overrun (start_overrun)
    );

    quad_sar_result_bank #(
        .DATA_W   (DATA_W),
        .CHANNELS (CHANNELS)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .rewind    (accept),
        .busy      (hold),
        .wr_en     (wr_en),
        .wr_idx    (CW'(sar_chan)),
        .wr_data   (wr_data),
        .rd_act    (rd_act),
        .rd_data   (rd_data),
        .irq_n     (irq_n),
        .busy_read (busy_read)
    );

    assign db = rd_act ? rd_data : {DATA_W{1'bz}};

    // R4: the interrupt never falls while the holds stay frozen
    assert_irq_ends_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $fell(hold));
endmodule

// File: tb/test_quad_sar_ctrl.sv
module test_quad_sar_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_start = 1'b0;
    logic        cmp_in;
    logic        hold;
    logic [1:0]  sar_chan;
    logic [11:0] sar_trial;
    logic        irq_n;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [11:0] db;
    logic        start_overrun;
    logic        busy_read;

    int checks = 0;
    int fails  = 0;
    int vals [4];
    int prev [4];
    bit finished = 1'b0;

    always #2 clk = ~clk;

    quad_sar_ctrl i_quad_sar_ctrl (
        .clk (clk), .rst (rst), .conv_start (conv_start), .cmp_in (cmp_in),
        .hold (hold), .sar_chan (sar_chan), .sar_trial (sar_trial),
        .irq_n (irq_n), .cs_n (cs_n), .rd_n (rd_n), .db (db),
        .start_overrun (start_overrun), .busy_read (busy_read)
    );

    // ideal comparator: sampled level in offset binary vs trial code
    always_comb cmp_in = (int'(sar_trial) <= vals[sar_chan] + 2048);

    function automatic logic [11:0] code_of(input int v);
        return 12'(v);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input string req, input logic [11:0] exp);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        #1 check(req, 32'(db), 32'(exp));
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    // mode: 0 plain, 1 second start at edge 20, 2 read at edge 30
    task automatic run_conv(input int mode);
        int edges = 0;
        int seq_err = 0;
        int last_ch = 0;
        logic [11:0] last_trial = 12'h0;
        for (int k = 0; k < 4; k++) prev[k] = vals[k];
        @(negedge clk);
        conv_start = 1'b1;
        while (edges < 200) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (edges == 2) begin
                check("R1 hold low after edge 2", 32'(hold), 32'd0);
                conv_start = 1'b0;
            end
            if (edges == 3) check("R1 hold high after edge 3", 32'(hold), 32'd1);
            if (hold) begin
                if (int'(sar_chan) != last_ch) begin
                    if (int'(sar_chan) != last_ch + 1) seq_err++;
                    last_ch = int'(sar_chan);
                end
                if (last_trial == 12'h0 && sar_trial != 12'h0 && sar_trial != 12'h800) seq_err++;
                last_trial = sar_trial;
            end
            if (mode == 1 && edges == 20) conv_start = 1'b1;
            if (mode == 1 && edges == 23) conv_start = 1'b0;
            if (mode == 2 && edges == 30) begin
                cs_n = 1'b0; rd_n = 1'b0;
                #1 check("R10 stale data during conversion", 32'(db), 32'(code_of(prev[0])));
            end
            if (mode == 2 && edges == 31) begin
                cs_n = 1'b1; rd_n = 1'b1;
            end
            if (!irq_n) break;
        end
        check("R4 edges to interrupt", 32'(edges), 32'd78);
        check("R4 hold released", 32'(hold), 32'd0);
        check("R3 R2 channel order and MSB-first trials", 32'(seq_err), 32'd0);
        check("R3 last channel reached", 32'(last_ch), 32'd3);
    endtask

    task automatic read_all(input string tag);
        do_read({tag, " R6 R2 ch1"}, code_of(vals[0]));
        check("R5 irq released after first read", 32'(irq_n), 32'd1);
        do_read({tag, " R6 R2 ch2"}, code_of(vals[1]));
        do_read({tag, " R6 R2 ch3"}, code_of(vals[2]));
        do_read({tag, " R6 R2 ch4"}, code_of(vals[3]));
    endtask

    initial begin
        for (int k = 0; k < 4; k++) vals[k] = 0;
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 irq_n", 32'(irq_n), 32'd1);
        check("R11 hold", 32'(hold), 32'd0);
        check("R11 flags", {30'd0, start_overrun, busy_read}, 32'd0);
        check("R8 bus z when idle", 32'(db === 12'hzzz), 32'd1);
        do_read("R11 register ch1 zero", 12'h000);
        do_read("R11 register ch2 zero", 12'h000);
        // R8 one strobe alone leaves the bus floating
        @(negedge clk); cs_n = 1'b0; #1 check("R8 cs only", 32'(db === 12'hzzz), 32'd1);
        cs_n = 1'b1; rd_n = 1'b0; #1 check("R8 rd only", 32'(db === 12'hzzz), 32'd1);
        rd_n = 1'b1;
        check("R5 irq high before any conversion", 32'(irq_n), 32'd1);

        // directed corners: extremes, zero, minus one
        vals = '{-2048, 2047, 0, -1};
        run_conv(0);
        read_all("corner");
        do_read("R7 wrap to ch1", code_of(vals[0]));
        check("R9 no overrun yet", 32'(start_overrun), 32'd0);

        vals = '{1, -2, 1365, -1366};
        run_conv(0);
        read_all("pattern");

        // random conversions
        for (int r = 0; r < 6; r++) begin
            for (int k = 0; k < 4; k++) vals[k] = int'($urandom % 4096) - 2048;
            run_conv(0);
            read_all("random");
        end

        // R9: start during conversion ignored
        for (int k = 0; k < 4; k++) vals[k] = int'($urandom % 4096) - 2048;
        run_conv(1);
        check("R9 overrun flag", 32'(start_overrun), 32'd1);
        read_all("R9 results unchanged");
        check("R9 overrun sticky", 32'(start_overrun), 32'd1);

        // R10: read during conversion
        check("R10 flag clear before", 32'(busy_read), 32'd0);
        for (int k = 0; k < 4; k++) vals[k] = int'($urandom % 4096) - 2048;
        run_conv(2);
        check("R10 busy_read flag", 32'(busy_read), 32'd1);
        read_all("R10 pointer not advanced");
        check("R10 busy_read sticky", 32'(busy_read), 32'd1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule